// File: doc/BRIEF.md
# Bridge Configuration-Space Shadow Shim

This block sits between a configuration-access requester and a root-port core. The core exposes a Type 0 header for its own port, but the software above it expects a Type 1 bridge. The shim accepts one configuration request per cycle. Each request carries bus, device, function, a 12-bit register offset, a size code and right-aligned write data. The shim settles the request in one of four ways: it drops the request as out of range, serves it from a small shadow register file, forwards it to the core with a rewritten address, or rejects it for an illegal size.

On the primary bus the bridge is seen as device 0, function 0. The core actually answers as device 1 on the secondary bus number, so primary-bus accesses that reach the core are moved to that location. Bridge-specific registers never reach the core. These are the base address registers, the bus numbers, the windows and the expansion ROM base. They live in the shadow file instead. Writes to the bus-number bytes are snooped: the new secondary bus number is driven to the core as its local bus number. When the core returns the header-type dword for a primary-bus read, the shim changes it so the header reads as Type 1.

Every request gets exactly one response, registered, in the cycle after the request.

Top module: `cfg_bridge_shim`

## Requirements
- R1: A request is valid only if it meets three rules. On the primary bus, only device 0 function 0 may be addressed. A bus other than the primary bus needs `link_up` high. On the secondary bus, only device 0 may be addressed. No other request is valid.
- R2: An invalid read returns all ones at the requested size: 0xFF for size code 0, 0xFFFF for code 1, 0xFFFFFFFF for code 2. An invalid write changes no state and raises no `core_valid`.
- R3: A valid primary-bus access to an offset in 0x10..0x33 or 0x38..0x3B uses shadow dword (offset-0x10)/4. It never raises `core_valid`. A read of it returns the stored bytes.
- R4: Any shadow write to the dwords at 0x10, 0x14 or 0x38 leaves the whole dword at zero.
- R5: After reset, the shadow dword at 0x1C reads 0x00000101. The dword at 0x24 reads 0x00010001. All other shadow dwords read zero. Both bus numbers are zero.
- R6: A shadow write whose offset is exactly 0x18, of any size, sets the primary bus number to byte 0 of the merged dword.
- R7: A shadow write at offset 0x19, or a 16- or 32-bit write at 0x18, sets the secondary bus number to byte 1 of the merged dword. `local_bus` shows this value from the next cycle on. `local_bus` changes for no other reason.
- R8: A forwarded access has `core_addr` = {1, 000, off[11:8], bus, dev, fn, off[7:2], 00}. Primary-bus accesses use (secondary bus, device 1, function 0). All other accesses keep their own bus, device and function.
- R9: For a primary-bus read forwarded to the dword at 0x0C, bits 22:16 of the core data are replaced with 0x01. Bit 23 and all other bits are kept, before lane extraction.
- R10: Lanes follow the size code. Code 0 is 8 bits at lane off[1:0]. Code 1 is 16 bits at halfword off[1]. Code 2 is the full dword. Write data is moved onto the lane with a matching `core_be`. Read data is returned right-aligned with the bits above the size cleared.
- R11: Size code 3 completes with `rsp_err` high and `rsp_rdata` zero. It has no core access and no state change.
- R12: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_up | input | 1 | Link to downstream device is up |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Register byte offset |
| req_size | input | 2 | 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = illegal |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | Response for previous cycle's request |
| rsp_rdata | output | 32 | Right-aligned read data |
| rsp_err | output | 1 | Illegal size response |
| core_valid | output | 1 | Forwarded access to the core this cycle |
| core_write | output | 1 | Forwarded access is a write |
| core_addr | output | 32 | Rewritten extended configuration address |
| core_wdata | output | 32 | Lane-aligned write data |
| core_be | output | 4 | Byte enables of the forwarded access |
| core_rdata | input | 32 | Core read dword, same cycle as `core_valid` |
| local_bus | output | 8 | Secondary bus number driven to the core |

## Verification
The assertions check, on every cycle, the properties that hold cycle by cycle. These are the one-cycle response timing, the error response for illegal sizes, the blocking of core access when the link is down, the all-ones value of dropped reads, the device 1 relocation of primary-bus forwards, the single-byte enable for byte accesses, and the rule that `local_bus` holds without a write. Only the bench scenarios can show the stored contents of the shadow file. That covers the reset codes, the forced-zero dwords, and byte and halfword merging over the whole shadowed range. The scenarios also cover the header-type patch value and the difference between the primary and secondary bus-number snoop for each write width and offset.

// File: rtl/cfg_shim_pkg.sv
package cfg_shim_pkg;

    localparam int BUS_W = 8;
    localparam int DEV_W = 5;
    localparam int FN_W  = 3;
    localparam int OFF_W = 12;
    localparam int DW    = 32;
    localparam int BE_W  = DW / 8;

    // shadow window
    localparam logic [OFF_W-1:0] SHW_BASE   = 12'h010;
    localparam logic [OFF_W-1:0] SHW_END_A  = 12'h034;
    localparam logic [OFF_W-1:0] SHW_BASE_B = 12'h038;
    localparam logic [OFF_W-1:0] SHW_END_B  = 12'h03C;
    localparam int SHW_WORDS = (SHW_END_B - SHW_BASE) / 4;
    localparam int SHW_IDX_W = $clog2(SHW_WORDS);

    // special offsets
    localparam logic [OFF_W-1:0] OFF_PRIM_BUS = 12'h018;
    localparam logic [OFF_W-1:0] OFF_SEC_BUS  = 12'h019;
    localparam logic [OFF_W-3:0] HDR_DWORD    = 10'h003;
    localparam logic [6:0]       HDR_TYPE1    = 7'h01;

    typedef enum logic [1:0] {
        SZ8    = 2'd0,
        SZ16   = 2'd1,
        SZ32   = 2'd2,
        SZ_BAD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        RT_DROP   = 2'd0,
        RT_SHADOW = 2'd1,
        RT_FWD    = 2'd2,
        RT_BAD    = 2'd3
    } route_e;

    typedef struct packed {
        logic              write;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   fn;
        logic [OFF_W-1:0]  off;
        size_e             size;
        logic [DW-1:0]     wdata;
    } cfg_req_t;

    function automatic logic [DW-1:0] size_mask(size_e sz);
        case (sz)
            SZ8:     return 32'h0000_00FF;
            SZ16:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [4:0] lane_shift(size_e sz, logic [1:0] lo);
        case (sz)
            SZ8:     return {lo, 3'b000};
            SZ16:    return {lo[1], 4'b0000};
            default: return 5'd0;
        endcase
    endfunction

    function automatic logic [BE_W-1:0] lane_be(size_e sz, logic [1:0] lo);
        case (sz)
            SZ8:     return 4'b0001 << lo;
            SZ16:    return lo[1] ? 4'b1100 : 4'b0011;
            SZ32:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [DW-1:0] lane_place(logic [DW-1:0] d, size_e sz, logic [1:0] lo);
        return (d & size_mask(sz)) << lane_shift(sz, lo);
    endfunction

    function automatic logic [DW-1:0] lane_pick(logic [DW-1:0] d, size_e sz, logic [1:0] lo);
        return (d >> lane_shift(sz, lo)) & size_mask(sz);
    endfunction

    function automatic logic [DW-1:0] byte_merge(logic [DW-1:0] old_d, logic [DW-1:0] new_d,
                                                 logic [BE_W-1:0] be);
        logic [DW-1:0] r;
        r = old_d;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[b*8 +: 8] = new_d[b*8 +: 8];
        end
        return r;
    endfunction

    // dwords that model fixed (non-programmable) base registers
    function automatic bit shw_is_ro(int idx);
        return (idx == 0) || (idx == 1) || (idx == 10);
    endfunction

    // reset contents: I/O range type codes and prefetch range type codes
    function automatic logic [DW-1:0] shw_init(int idx);
        case (idx)
            3:       return 32'h0000_0101;
            5:       return 32'h0001_0001;
            default: return 32'h0000_0000;
        endcase
    endfunction

endpackage

// File: rtl/cfg_route.sv
module cfg_route
    import cfg_shim_pkg::*;
(
    input  logic [BUS_W-1:0]     bus,
    input  logic [DEV_W-1:0]     dev,
    input  logic [FN_W-1:0]      fn,
    input  logic [OFF_W-1:0]     off,
    input  size_e                size,
    input  logic [BUS_W-1:0]     prim_bus,
    input  logic [BUS_W-1:0]     sec_bus,
    input  logic                 link_up,
    output route_e               route,
    output logic                 on_primary,
    output logic [SHW_IDX_W-1:0] shw_idx,
    output logic [DW-1:0]        fwd_addr
);
    logic addr_ok;
    logic in_shadow;
    logic [BUS_W-1:0] tgt_bus;
    logic [DEV_W-1:0] tgt_dev;
    logic [FN_W-1:0]  tgt_fn;

    always_comb begin
        on_primary = (bus == prim_bus);
        addr_ok = 1'b1;
        if (on_primary && (dev != '0 || fn != '0)) addr_ok = 1'b0;
        if (!on_primary && !link_up)                addr_ok = 1'b0;
        if (bus == sec_bus && dev != '0)            addr_ok = 1'b0;

        in_shadow = ((off >= SHW_BASE)   && (off < SHW_END_A)) ||
                    ((off >= SHW_BASE_B) && (off < SHW_END_B));

        if (size == SZ_BAD)                 route = RT_BAD;
        else if (!addr_ok)                  route = RT_DROP;
        else if (on_primary && in_shadow)   route = RT_SHADOW;
        else                                route = RT_FWD;
    end

    assign shw_idx = SHW_IDX_W'((off - SHW_BASE) >> 2);

    // bridge lives at device 1 of the secondary bus number inside the core
    assign tgt_bus = on_primary ? sec_bus : bus;
    assign tgt_dev = on_primary ? DEV_W'(1) : dev;
    assign tgt_fn  = on_primary ? '0 : fn;

    assign fwd_addr = {1'b1, 3'b000, off[11:8], tgt_bus, tgt_dev, tgt_fn, off[7:2], 2'b00};

endmodule

// File: rtl/cfg_shadow.sv
module cfg_shadow
    import cfg_shim_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SHW_IDX_W-1:0] idx,
    input  logic [OFF_W-1:0]     off,
    input  size_e                size,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rd_dword,
    output logic [BUS_W-1:0]     prim_bus,
    output logic [BUS_W-1:0]     sec_bus
);
    logic [DW-1:0] words [SHW_WORDS];
    logic [DW-1:0] merged;
    logic [DW-1:0] cur;

    assign cur      = (int'(idx) < SHW_WORDS) ? words[idx] : '0;
    assign rd_dword = cur;
    assign merged   = byte_merge(cur, lane_place(wdata, size, off[1:0]), lane_be(size, off[1:0]));

    for (genvar i = 0; i < SHW_WORDS; i++) begin : g_word
        localparam bit RO = shw_is_ro(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                words[i] <= shw_init(i);
            end else if (wr_en && int'(idx) == i) begin
                words[i] <= RO ? '0 : merged;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_bus <= '0;
            sec_bus  <= '0;
        end else if (wr_en) begin
            if (off == OFF_PRIM_BUS)
                prim_bus <= merged[7:0];
            if (off == OFF_SEC_BUS || (off == OFF_PRIM_BUS && size != SZ8))
                sec_bus <= merged[15:8];
        end
    end

endmodule

// File: rtl/cfg_respond.sv
module cfg_respond
    import cfg_shim_pkg::*;
(
    input  route_e          route,
    input  logic            write,
    input  size_e           size,
    input  logic [1:0]      lo,
    input  logic            hdr_patch,
    input  logic [DW-1:0]   shw_dword,
    input  logic [DW-1:0]   core_dword,
    output logic [DW-1:0]   rdata,
    output logic            err
);
    logic [DW-1:0] fixed;

    always_comb begin
        fixed = core_dword;
        if (hdr_patch) fixed[22:16] = HDR_TYPE1;

        err   = 1'b0;
        rdata = '0;
        case (route)
            RT_BAD:    err = 1'b1;
            RT_DROP:   rdata = write ? '0 : size_mask(size);
            RT_SHADOW: rdata = write ? '0 : lane_pick(shw_dword, size, lo);
            default:   rdata = write ? '0 : lane_pick(fixed, size, lo);
        endcase
    end

endmodule

// File: rtl/cfg_bridge_shim.sv
module cfg_bridge_shim
    import cfg_shim_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        link_up,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_dev,
    input  logic [2:0]  req_fn,
    input  logic [11:0] req_off,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_err,
    output logic        core_valid,
    output logic        core_write,
    output logic [31:0] core_addr,
    output logic [31:0] core_wdata,
    output logic [3:0]  core_be,
    input  logic [31:0] core_rdata,
    output logic [7:0]  local_bus
);
    cfg_req_t             req;
    route_e               route;
    logic                 on_primary;
    logic [SHW_IDX_W-1:0] shw_idx;
    logic [DW-1:0]        fwd_addr;
    logic [DW-1:0]        shw_dword;
    logic [BUS_W-1:0]     prim_bus_q;
    logic [BUS_W-1:0]     sec_bus_q;
    logic [DW-1:0]        rdata_d;
    logic                 err_d;
    logic                 hdr_patch;

    assign req = '{write: req_write, bus: req_bus, dev: req_dev, fn: req_fn,
                   off: req_off, size: size_e'(req_size), wdata: req_wdata};

    cfg_route u_route (
        .bus        (req.bus),
        .dev        (req.dev),
        .fn         (req.fn),
        .off        (req.off),
        .size       (req.size),
        .prim_bus   (prim_bus_q),
        .sec_bus    (sec_bus_q),
        .link_up    (link_up),
        .route      (route),
        .on_primary (on_primary),
        .shw_idx    (shw_idx),
        .fwd_addr   (fwd_addr)
    );

    cfg_shadow u_shadow (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (req_valid && req.write && route == RT_SHADOW),
        .idx      (shw_idx),
        .off      (req.off),
        .size     (req.size),
        .wdata    (req.wdata),
        .rd_dword (shw_dword),
        .prim_bus (prim_bus_q),
        .sec_bus  (sec_bus_q)
    );

    assign hdr_patch = on_primary && !req.write && (req.off[OFF_W-1:2] == HDR_DWORD);

    cfg_respond u_resp (
        .route      (route),
        .write      (req.write),
        .size       (req.size),
        .lo         (req.off[1:0]),
        .hdr_patch  (hdr_patch),
        .shw_dword  (shw_dword),
        .core_dword (core_rdata),
        .rdata      (rdata_d),
        .err        (err_d)
    );

    assign core_valid = req_valid && route == RT_FWD;
    assign core_write = req.write;
    assign core_addr  = fwd_addr;
    assign core_wdata = lane_place(req.wdata, req.size, req.off[1:0]);
    assign core_be    = lane_be(req.size, req.off[1:0]);
    assign local_bus  = sec_bus_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= req_valid ? rdata_d : '0;
            rsp_err   <= req_valid && err_d;
        end
    end

endmodule

// File: rtl/cfg_shim_chk.sv
module cfg_shim_chk (
    input logic        clk,
    input logic        rst,
    input logic        link_up,
    input logic        req_valid,
    input logic        req_write,
    input logic [7:0]  req_bus,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic [31:0] rsp_rdata,
    input logic        rsp_err,
    input logic        core_valid,
    input logic [31:0] core_addr,
    input logic [3:0]  core_be,
    input logic [7:0]  local_bus,
    input logic [7:0]  prim_bus
);
    // R12
    rsp_timing_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R12
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R11
    bad_size_no_core_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd3) |-> !core_valid);
    // R11
    bad_size_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd3) |=> (rsp_err && rsp_rdata == 32'd0));
    // R1
    link_down_block_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bus != prim_bus && !link_up) |-> !core_valid);
    // R2
    drop_read_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size != 2'd3 && req_bus != prim_bus && !link_up)
        |=> rsp_rdata == ($past(req_size) == 2'd0 ? 32'h0000_00FF :
                          $past(req_size) == 2'd1 ? 32'h0000_FFFF : 32'hFFFF_FFFF));
    // R8
    relocate_chk: assert property (@(posedge clk) disable iff (rst)
        (core_valid && req_bus == prim_bus)
        |-> (core_addr[15:8] == 8'h08 && core_addr[23:16] == local_bus && core_addr[31]));
    // R10
    byte_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (core_valid && req_size == 2'd0) |-> $countones(core_be) == 1);
    // R7
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> $stable(local_bus));
endmodule

bind cfg_bridge_shim cfg_shim_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_up    (link_up),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_bus    (req_bus),
    .req_size   (req_size),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .core_valid (core_valid),
    .core_addr  (core_addr),
    .core_be    (core_be),
    .local_bus  (local_bus),
    .prim_bus   (prim_bus_q)
);

// File: tb/tb_cfg_bridge_shim.sv
module tb_cfg_bridge_shim;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_up = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_fn = '0;
    logic [11:0] req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err, core_valid, core_write;
    logic [31:0] rsp_rdata, core_addr, core_wdata, core_rdata;
    logic [3:0]  core_be;
    logic [7:0]  local_bus;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic        c_cv, c_cw, r_valid, r_err;
    logic [31:0] c_addr, c_wd, r_data;
    logic [3:0]  c_be;

    always #2 clk = ~clk;

    function automatic logic [31:0] core_model(logic [31:0] a);
        return a ^ 32'h5AC3_96E1;
    endfunction

    function automatic logic [31:0] exp_addr(int bus, int dev, int fn, int off);
        logic [11:0] o;
        o = 12'(off);
        return {1'b1, 3'b000, o[11:8], 8'(bus), 5'(dev), 3'(fn), o[7:2], 2'b00};
    endfunction

    assign core_rdata = core_model(core_addr);

    cfg_bridge_shim dut (
        .clk(clk), .rst(rst), .link_up(link_up),
        .req_valid(req_valid), .req_write(req_write), .req_bus(req_bus),
        .req_dev(req_dev), .req_fn(req_fn), .req_off(req_off),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .core_valid(core_valid), .core_write(core_write), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_be(core_be), .core_rdata(core_rdata),
        .local_bus(local_bus)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic access(bit w, int bus, int dev, int fn, int off, int sz, logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_bus = 8'(bus); req_dev = 5'(dev);
        req_fn = 3'(fn); req_off = 12'(off); req_size = 2'(sz); req_wdata = wd;
        #1;
        c_cv = core_valid; c_cw = core_write; c_addr = core_addr;
        c_wd = core_wdata; c_be = core_be;
        @(negedge clk);
        req_valid = 1'b0;
        r_valid = rsp_valid; r_data = rsp_rdata; r_err = rsp_err;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  vb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5 reset state of outputs
        chk("R5 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
        chk("R5 local_bus after reset", {24'd0, local_bus}, 32'd0);
        chk("R5 core_valid idle", {31'd0, core_valid}, 32'd0);

        // R5 reset shadow contents, byte lanes R10
        for (int b = 0; b < 4; b++) begin
            access(0, 0, 0, 0, 'h1C + b, 0, 0);
            chk($sformatf("R5 io type byte %0d", b), r_data, (b < 2) ? 32'h01 : 32'h00);
        end
        access(0, 0, 0, 0, 'h24, 2, 0);
        chk("R5 prefetch type dword", r_data, 32'h0001_0001);
        access(0, 0, 0, 0, 'h26, 1, 0);
        chk("R5 R10 prefetch upper half", r_data, 32'h0000_0001);
        chk("R12 rsp_valid after read", {31'd0, r_valid}, 32'd1);

        // R3 R4 R10 sweep over shadow bytes (skip bus-number dword and 0x34)
        for (int i = 0; i < 11; i++) begin
            if (i == 2 || i == 9) continue;
            for (int b = 0; b < 4; b++) begin
                vb = 8'(8'hA0 ^ (i * 4 + b) ^ 8'h5B);
                access(1, 0, 0, 0, 'h10 + i * 4 + b, 0, {24'hFFFFFF, vb});
                chk("R3 shadow write no core", {31'd0, c_cv}, 32'd0);
            end
            for (int b = 0; b < 4; b++) begin
                vb = 8'(8'hA0 ^ (i * 4 + b) ^ 8'h5B);
                access(0, 0, 0, 0, 'h10 + i * 4 + b, 0, 0);
                chk("R3 shadow read no core", {31'd0, c_cv}, 32'd0);
                chk($sformatf("R3 R4 shadow byte idx %0d lane %0d", i, b), r_data,
                    (i == 0 || i == 1 || i == 10) ? 32'd0 : {24'd0, vb});
            end
        end
        access(1, 0, 0, 0, 'h22, 1, 32'hFFFF_BEEF);
        access(0, 0, 0, 0, 'h20, 2, 0);
        d = {16'hBEEF, 8'(8'hA0 ^ 8'd17 ^ 8'h5B), 8'(8'hA0 ^ 8'd16 ^ 8'h5B)};
        chk("R10 halfword merge", r_data, d);
        access(1, 0, 0, 0, 'h14, 2, 32'h1234_5678);
        access(0, 0, 0, 0, 'h14, 2, 0);
        chk("R4 bar1 dword zero", r_data, 32'd0);

        // R11 illegal size
        access(1, 0, 0, 0, 'h20, 3, 32'h0);
        chk("R11 err", {31'd0, r_err}, 32'd1);
        chk("R11 no core", {31'd0, c_cv}, 32'd0);
        chk("R11 rdata zero", r_data, 32'd0);
        access(0, 0, 0, 0, 'h20, 2, 0);
        chk("R11 shadow unchanged", r_data, d);

        // R7 secondary via byte at 0x19
        access(1, 0, 0, 0, 'h19, 0, 32'h05);
        chk("R7 local_bus from 0x19", {24'd0, local_bus}, 32'd5);
        // R6 R7 halfword at 0x18
        access(1, 0, 0, 0, 'h18, 1, 32'h0302);
        chk("R7 local_bus from 0x18 half", {24'd0, local_bus}, 32'd3);
        access(0, 2, 0, 0, 'h18, 2, 0);
        chk("R6 primary is now 2", r_data, 32'h0000_0302);
        chk("R6 primary shadow no core", {31'd0, c_cv}, 32'd0);
        // R6 byte at 0x18 changes primary only
        access(1, 2, 0, 0, 'h18, 0, 32'h04);
        chk("R7 byte at 0x18 keeps secondary", {24'd0, local_bus}, 32'd3);
        access(0, 4, 0, 0, 'h18, 2, 0);
        chk("R6 primary now 4", r_data, 32'h0000_0304);

        // R8 primary forward relocated to (sec,1,0)
        access(0, 4, 0, 0, 'h00, 2, 0);
        chk("R8 primary fwd valid", {31'd0, c_cv}, 32'd1);
        chk("R8 primary fwd addr", c_addr, exp_addr(3, 1, 0, 'h00));
        chk("R8 primary fwd data", r_data, core_model(exp_addr(3, 1, 0, 'h00)));
        access(1, 4, 0, 0, 'h05, 0, 32'h0000_0047);
        chk("R8 fwd write addr", c_addr, exp_addr(3, 1, 0, 'h05));
        chk("R10 byte write lane data", c_wd, 32'h0000_4700);
        chk("R10 byte write be", {28'd0, c_be}, 32'h2);
        chk("R8 fwd write flag", {31'd0, c_cw}, 32'd1);

        // R9 header patch
        d = core_model(exp_addr(3, 1, 0, 'h0C));
        d[22:16] = 7'h01;
        access(0, 4, 0, 0, 'h0C, 2, 0);
        chk("R9 header dword", r_data, d);
        access(0, 4, 0, 0, 'h0E, 0, 0);
        chk("R9 header byte", r_data, (d >> 16) & 32'hFF);
        access(0, 4, 0, 0, 'h08, 2, 0);
        chk("R9 other dword untouched", r_data, core_model(exp_addr(3, 1, 0, 'h08)));

        // R1 R2 invalid accesses
        access(0, 4, 1, 0, 'h00, 2, 0);
        chk("R1 primary dev1 no core", {31'd0, c_cv}, 32'd0);
        chk("R2 primary dev1 ones", r_data, 32'hFFFF_FFFF);
        access(0, 4, 0, 2, 'h00, 0, 0);
        chk("R2 primary fn2 ones byte", r_data, 32'h0000_00FF);
        access(0, 3, 0, 0, 'h00, 1, 0);
        chk("R1 link down no core", {31'd0, c_cv}, 32'd0);
        chk("R2 link down ones half", r_data, 32'h0000_FFFF);
        access(1, 3, 0, 0, 'h19, 0, 32'h77);
        chk("R2 invalid write no core", {31'd0, c_cv}, 32'd0);
        chk("R2 invalid write keeps bus", {24'd0, local_bus}, 32'd3);

        link_up = 1'b1;
        access(0, 3, 0, 2, 'h02, 1, 0);
        chk("R8 secondary keeps bdf", c_addr, exp_addr(3, 0, 2, 'h02));
        chk("R10 secondary half read", r_data, (core_model(exp_addr(3, 0, 2, 'h02)) >> 16) & 32'hFFFF);
        access(0, 3, 2, 0, 'h00, 2, 0);
        chk("R1 secondary dev2 no core", {31'd0, c_cv}, 32'd0);
        chk("R2 secondary dev2 ones", r_data, 32'hFFFF_FFFF);
        access(1, 7, 3, 1, 'h106, 1, 32'h0000_BEEF);
        chk("R1 deeper bus valid", {31'd0, c_cv}, 32'd1);
        chk("R8 extended offset addr", c_addr, exp_addr(7, 3, 1, 'h106));
        chk("R10 half write data", c_wd, 32'hBEEF_0000);
        chk("R10 half write be", {28'd0, c_be}, 32'hC);
        access(0, 4, 0, 0, 'h34, 2, 0);
        chk("R3 0x34 forwarded", {31'd0, c_cv}, 32'd1);

        @(negedge clk);
        chk("R12 idle no rsp", {31'd0, rsp_valid}, 32'd0);
        finish_run();
    end
endmodule